// File: doc/BRIEF.md
# Double-Buffered Quad DAC Register Bank

This block is the register core that sits behind the serial front end of a four-channel digital-to-analog converter. Each channel has two levels of storage. The host writes a staging level, called the input buffer. An update then copies the staging level into the active level, called the DAC buffer, and the analog side reads the active level. Each level holds a 16-bit code and a 4-bit output-range (span) selector.

Commands arrive on a framed strobe. The host holds `frame_n` low for the length of a frame and presents an opcode, an address and a data word. The command takes effect on the clock edge at which `frame_n` is first seen high again. The port has no back-pressure: every frame that completes is accepted. A level-sensitive `ldac_n` input updates all channels at once.

Three events put the bank into a known state:
- A system clear (`clr_n` low) zeroes only the active level, so a later update brings back the previous outputs. A clear that arrives while a frame is open also cancels that frame's command.
- A supply dip reported on `brownout_n` returns every register to its power-up value.
- Power-on reset does the same.

An active-low integrity flag tells the host that the outputs have lost their programmed state. A readback port shows the staging level of any channel, so the host can verify the contents after an aborted frame.

Top module: `qdac_regbank`

## Requirements
- R1: After power-on reset, every code and span in both levels of all four channels is zero (span 4'b0000 is the unipolar 0 V to 5 V range), and `integrity_n` is low.
- R2: Opcode 4'h0 writes `cmd_data` into the addressed staging codes. Opcode 4'h1 writes `cmd_data[3:0]` into the addressed staging spans. Neither opcode changes `dac_code_o` or `dac_span_o`. Opcode 4'hF and all unlisted opcodes change nothing.
- R3: Opcode 4'h2 copies code and span from staging to active for the addressed channels only. Address 0 to 3 selects one channel, address 4'hF selects all four, and any other address selects none.
- R4: Opcode 4'h3 writes `cmd_data` into the addressed staging codes and, on the same edge, makes it the active code of those channels.
- R5: While `clr_n` is low, every active code and span is forced to zero and the staging level keeps its contents. A later update restores the staged values.
- R6: If `clr_n` is low during an open frame (`frame_n` low), the command of that frame is not carried out when the frame closes.
- R7: `ldac_n` low at a clock edge with no frame open and `clr_n` high updates all four channels. While a frame is open, `ldac_n` has no effect.
- R8: With `manual_span` high, every update loads `strap_span` into the active span of all four channels on the same edge as the code copy, and span writes (opcode 4'h1) leave the staging spans unchanged.
- R9: `integrity_n` goes low at reset, while `clr_n` is low and while `brownout_n` is low. It returns high on the first update that touches at least one channel.
- R10: `brownout_n` low at a clock edge returns every register to its R1 value.
- R11: `rd_code_o` and `rd_span_o` show, combinationally, the staging code and span of the channel chosen by `rd_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| brownout_n | input | 1 | Synchronous supply-dip indication, active low |
| clr_n | input | 1 | System clear, active low |
| frame_n | input | 1 | Command frame strobe, low while a frame is open |
| cmd_op | input | 4 | Command opcode |
| cmd_addr | input | 4 | Channel address (4'hF selects all channels) |
| cmd_data | input | 16 | Code, or span in bits [3:0] |
| ldac_n | input | 1 | Load-all update request, active low |
| manual_span | input | 1 | Selects strap-driven span mode |
| strap_span | input | 4 | Strapped span value |
| rd_sel | input | 2 | Readback channel select |
| rd_code_o | output | 16 | Staging code of the selected channel |
| rd_span_o | output | 4 | Staging span of the selected channel |
| dac_code_o | output | 64 | Active codes, channel i at [16i+15:16i] |
| dac_span_o | output | 16 | Active spans, channel i at [4i+3:4i] |
| integrity_n | output | 1 | Data-integrity flag, active low |

## Verification
The hardest case to reach from the ports is a clear that lands inside an open frame. The bench opens a write-and-update frame and pulses `clr_n` low while `frame_n` is still low, then closes the frame one cycle later. It checks that the active level is zero and that the staging code is still the old value. A following `ldac_n` pulse must then restore the old code and not the aborted one. A second sequence pulses `ldac_n` inside an open no-op frame to show that the pulse is ignored.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int NUM_CH_D = 4;
  localparam int CODE_W_D = 16;
  localparam int SPAN_W_D = 4;
  localparam int ADDR_W_D = 4;

  typedef enum logic [3:0] {
    OP_WR_CODE = 4'h0,
    OP_WR_SPAN = 4'h1,
    OP_UPDATE  = 4'h2,
    OP_WR_UPD  = 4'h3,
    OP_NOP     = 4'hF
  } op_e;
endpackage

// File: rtl/qdac_frame_ctl.sv
module qdac_frame_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wipe,
  input  logic clr_n,
  input  logic frame_n,
  output logic frame_open,
  output logic exec
);
  logic frame_q, abort_q, rise;

  assign rise       = !frame_q && frame_n;
  assign exec       = rise && !abort_q && clr_n;
  assign frame_open = !frame_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= 1'b1;
      abort_q <= 1'b0;
    end else if (wipe) begin
      frame_q <= 1'b1;
      abort_q <= 1'b0;
    end else begin
      frame_q <= frame_n;
      if (!frame_n && !clr_n) abort_q <= 1'b1;
      else if (rise)          abort_q <= 1'b0;
    end
  end

  // R6: a clear inside an open frame suppresses the command at frame close
  assert_abort_frame_R6: assert property (@(posedge clk) disable iff (!rst_n || wipe)
    (!frame_n && !clr_n) |=> !exec);
endmodule

// File: rtl/qdac_channel.sv
module qdac_channel #(
  parameter int CODE_W = 16,
  parameter int SPAN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wipe,
  input  logic              clr,
  input  logic              wr_code,
  input  logic              wr_span,
  input  logic              upd,
  input  logic              force_span,
  input  logic [CODE_W-1:0] din_code,
  input  logic [SPAN_W-1:0] din_span,
  input  logic [SPAN_W-1:0] strap,
  output logic [CODE_W-1:0] in_code,
  output logic [SPAN_W-1:0] in_span,
  output logic [CODE_W-1:0] dac_code,
  output logic [SPAN_W-1:0] dac_span
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_code  <= '0;
      in_span  <= '0;
      dac_code <= '0;
      dac_span <= '0;
    end else if (wipe) begin
      in_code  <= '0;
      in_span  <= '0;
      dac_code <= '0;
      dac_span <= '0;
    end else begin
      if (wr_code) in_code <= din_code;
      if (wr_span) in_span <= din_span;
      if (clr) begin
        dac_code <= '0;
        dac_span <= '0;
      end else begin
        if (upd)             dac_code <= wr_code ? din_code : in_code;
        if (force_span)      dac_span <= strap;
        else if (upd)        dac_span <= in_span;
      end
    end
  end

  // R5: clear empties the active level
  assert_clear_zeroes_R5: assert property (@(posedge clk) disable iff (!rst_n || wipe)
    clr |=> (dac_code == '0 && dac_span == '0));
  // R5: clear leaves the staging level alone
  assert_clear_keeps_stage_R5: assert property (@(posedge clk) disable iff (!rst_n || wipe)
    clr |=> ($stable(in_code) && $stable(in_span)));
endmodule

// File: rtl/qdac_regbank.sv
module qdac_regbank
  import qdac_pkg::*;
#(
  parameter int NUM_CH = NUM_CH_D,
  parameter int CODE_W = CODE_W_D,
  parameter int SPAN_W = SPAN_W_D,
  parameter int ADDR_W = ADDR_W_D,
  localparam int SEL_W = $clog2(NUM_CH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       brownout_n,
  input  logic                       clr_n,
  input  logic                       frame_n,
  input  logic [3:0]                 cmd_op,
  input  logic [ADDR_W-1:0]          cmd_addr,
  input  logic [CODE_W-1:0]          cmd_data,
  input  logic                       ldac_n,
  input  logic                       manual_span,
  input  logic [SPAN_W-1:0]          strap_span,
  input  logic [SEL_W-1:0]           rd_sel,
  output logic [CODE_W-1:0]          rd_code_o,
  output logic [SPAN_W-1:0]          rd_span_o,
  output logic [NUM_CH*CODE_W-1:0]   dac_code_o,
  output logic [NUM_CH*SPAN_W-1:0]   dac_span_o,
  output logic                       integrity_n
);
  localparam logic [ADDR_W-1:0] ADDR_ALL = '1;

  logic wipe, clr, exec, frame_open, ldac_go, any_upd, force_span, flag_q;
  op_e  op;
  logic [NUM_CH-1:0] sel, wr_code, wr_span, upd;
  logic [CODE_W-1:0] in_code_a [NUM_CH];
  logic [SPAN_W-1:0] in_span_a [NUM_CH];

  assign wipe = !brownout_n;
  assign clr  = !clr_n;
  assign op   = op_e'(cmd_op);

  qdac_frame_ctl u_frame (
    .clk(clk), .rst_n(rst_n), .wipe(wipe), .clr_n(clr_n),
    .frame_n(frame_n), .frame_open(frame_open), .exec(exec)
  );

  assign ldac_go    = !ldac_n && !frame_open && clr_n;
  assign any_upd    = |upd;
  assign force_span = manual_span && any_upd;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign sel[i]     = (cmd_addr == ADDR_ALL) || (cmd_addr == ADDR_W'(i));
    assign wr_code[i] = exec && sel[i] && (op == OP_WR_CODE || op == OP_WR_UPD);
    assign wr_span[i] = exec && sel[i] && (op == OP_WR_SPAN) && !manual_span;
    assign upd[i]     = ldac_go || (exec && sel[i] && (op == OP_UPDATE || op == OP_WR_UPD));

    qdac_channel #(.CODE_W(CODE_W), .SPAN_W(SPAN_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .wipe(wipe), .clr(clr),
      .wr_code(wr_code[i]), .wr_span(wr_span[i]), .upd(upd[i]),
      .force_span(force_span),
      .din_code(cmd_data), .din_span(cmd_data[SPAN_W-1:0]), .strap(strap_span),
      .in_code(in_code_a[i]), .in_span(in_span_a[i]),
      .dac_code(dac_code_o[i*CODE_W +: CODE_W]),
      .dac_span(dac_span_o[i*SPAN_W +: SPAN_W])
    );
  end

  assign rd_code_o = in_code_a[rd_sel];
  assign rd_span_o = in_span_a[rd_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b1;
    else if (wipe)    flag_q <= 1'b1;
    else if (clr)     flag_q <= 1'b1;
    else if (any_upd) flag_q <= 1'b0;
  end
  assign integrity_n = !flag_q;

  // R9: clear raises the integrity flag
  assert_flag_on_clear_R9: assert property (@(posedge clk) disable iff (!rst_n || wipe)
    !clr_n |=> !integrity_n);
  // R10: brownout returns outputs to power-up values
  assert_brownout_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !brownout_n |=> (dac_code_o == '0 && dac_span_o == '0 && !integrity_n));
  // R7: no active code moves while a frame is open
  assert_frame_blocks_ldac_R7: assert property (@(posedge clk) disable iff (!rst_n || wipe)
    (!frame_n && clr_n) |=> $stable(dac_code_o));
  // R8: manual mode spans follow the strap on every update
  assert_manual_span_R8: assert property (@(posedge clk) disable iff (!rst_n || wipe)
    (manual_span && any_upd && clr_n) |=> (dac_span_o == {NUM_CH{$past(strap_span)}}));
endmodule

// File: tb/qdac_regbank_test.sv
module qdac_regbank_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0, brownout_n = 1'b1, clr_n = 1'b1, frame_n = 1'b1;
  logic [3:0] cmd_op = 4'hF, cmd_addr = 4'h0, strap_span = 4'h0;
  logic [15:0] cmd_data = 16'h0;
  logic ldac_n = 1'b1, manual_span = 1'b0;
  logic [1:0] rd_sel = 2'd0;
  logic [15:0] rd_code_o;
  logic [3:0]  rd_span_o;
  logic [63:0] dac_code_o;
  logic [15:0] dac_span_o;
  logic integrity_n;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  qdac_regbank uut (
    .clk(clk), .rst_n(rst_n), .brownout_n(brownout_n), .clr_n(clr_n),
    .frame_n(frame_n), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .ldac_n(ldac_n), .manual_span(manual_span), .strap_span(strap_span),
    .rd_sel(rd_sel), .rd_code_o(rd_code_o), .rd_span_o(rd_span_o),
    .dac_code_o(dac_code_o), .dac_span_o(dac_span_o), .integrity_n(integrity_n)
  );

  typedef struct {
    string       tag;
    logic [63:0] codes;
    logic [15:0] spans;
    logic        flag_n;
    logic [15:0] rbc;
    logic [3:0]  rbs;
  } exp_t;
  exp_t sbq[$];
  event chk_ev;

  logic [15:0] m_in_code [4];
  logic [3:0]  m_in_span [4];
  logic [15:0] m_dac_code [4];
  logic [3:0]  m_dac_span [4];
  logic        m_flag;

  task automatic m_wipe();
    for (int i = 0; i < 4; i++) begin
      m_in_code[i] = '0; m_in_span[i] = '0; m_dac_code[i] = '0; m_dac_span[i] = '0;
    end
    m_flag = 1'b1;
  endtask

  task automatic m_clear();
    for (int i = 0; i < 4; i++) begin m_dac_code[i] = '0; m_dac_span[i] = '0; end
    m_flag = 1'b1;
  endtask

  task automatic m_update(input logic [3:0] mask);
    for (int i = 0; i < 4; i++)
      if (mask[i]) begin m_dac_code[i] = m_in_code[i]; m_dac_span[i] = m_in_span[i]; end
    if (mask != 0) begin
      m_flag = 1'b0;
      if (manual_span) for (int i = 0; i < 4; i++) m_dac_span[i] = strap_span;
    end
  endtask

  task automatic m_cmd(input logic [3:0] op, input logic [3:0] addr, input logic [15:0] d);
    logic [3:0] mask;
    for (int i = 0; i < 4; i++) mask[i] = (addr == 4'hF) || (addr == 4'(i));
    case (op)
      4'h0: for (int i = 0; i < 4; i++) if (mask[i]) m_in_code[i] = d;
      4'h1: if (!manual_span) for (int i = 0; i < 4; i++) if (mask[i]) m_in_span[i] = d[3:0];
      4'h2: m_update(mask);
      4'h3: begin
        for (int i = 0; i < 4; i++) if (mask[i]) m_in_code[i] = d;
        m_update(mask);
      end
      default: ;
    endcase
  endtask

  task automatic push(input string tag);
    exp_t e;
    e.tag = tag; e.flag_n = !m_flag;
    for (int i = 0; i < 4; i++) begin
      e.codes[i*16 +: 16] = m_dac_code[i];
      e.spans[i*4 +: 4]   = m_dac_span[i];
    end
    e.rbc = m_in_code[rd_sel]; e.rbs = m_in_span[rd_sel];
    sbq.push_back(e);
    ->chk_ev;
    #1;
  endtask

  task automatic cmp(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(chk_ev);
      while (sbq.size() > 0) begin
        e = sbq.pop_front();
        cmp(e.tag, "dac_code", dac_code_o, e.codes);
        cmp(e.tag, "dac_span", 64'(dac_span_o), 64'(e.spans));
        cmp(e.tag, "integrity_n", 64'(integrity_n), 64'(e.flag_n));
        cmp(e.tag, "rd_code", 64'(rd_code_o), 64'(e.rbc));
        cmp(e.tag, "rd_span", 64'(rd_span_o), 64'(e.rbs));
      end
    end
  end

  task automatic do_cmd(input string tag, input logic [3:0] op, input logic [3:0] addr,
                        input logic [15:0] d, input bit abort);
    @(negedge clk);
    frame_n = 1'b0; cmd_op = op; cmd_addr = addr; cmd_data = d;
    @(negedge clk);
    if (abort) begin
      clr_n = 1'b0;
      @(negedge clk);
      clr_n = 1'b1;
    end
    frame_n = 1'b1;
    @(negedge clk);
    if (abort) m_clear(); else m_cmd(op, addr, d);
    cmd_op = 4'hF;
    push(tag);
  endtask

  task automatic do_ldac(input string tag, input bit in_frame);
    @(negedge clk);
    if (in_frame) begin frame_n = 1'b0; cmd_op = 4'hF; end
    ldac_n = 1'b0;
    @(negedge clk);
    if (!in_frame) m_update(4'hF);
    push(tag);
    ldac_n = 1'b1; frame_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_clear(input string tag);
    @(negedge clk); clr_n = 1'b0;
    @(negedge clk); m_clear(); push(tag);
    clr_n = 1'b1;
  endtask

  task automatic do_brownout(input string tag);
    @(negedge clk); brownout_n = 1'b0;
    @(negedge clk); m_wipe(); push(tag);
    brownout_n = 1'b1;
  endtask

  initial begin : driver
    m_wipe();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    push("R1 reset state");
    rd_sel = 2'd0;
    do_cmd("R2 write code ch0", 4'h0, 4'h0, 16'h1234, 0);
    do_cmd("R2 write span ch0", 4'h1, 4'h0, 16'h0003, 0);
    do_cmd("R2 unlisted opcode", 4'h7, 4'hF, 16'hDEAD, 0);
    do_cmd("R3 R9 update ch0", 4'h2, 4'h0, 16'h0000, 0);
    rd_sel = 2'd1;
    do_cmd("R2 broadcast write", 4'h0, 4'hF, 16'hABCD, 0);
    do_cmd("R3 update ch1 only", 4'h2, 4'h1, 16'h0000, 0);
    rd_sel = 2'd2;
    do_cmd("R4 write-and-update ch2", 4'h3, 4'h2, 16'h5555, 0);
    do_cmd("R3 unused address", 4'h3, 4'h7, 16'h7777, 0);
    rd_sel = 2'd0;
    do_clear("R5 R9 clear");
    do_ldac("R7 R5 ldac restore", 0);
    rd_sel = 2'd3;
    do_cmd("R2 write code ch3", 4'h0, 4'h3, 16'h0F0F, 0);
    do_ldac("R7 ldac inside frame ignored", 1);
    do_cmd("R6 aborted frame", 4'h3, 4'h3, 16'h9999, 1);
    do_ldac("R6 R5 restore after abort", 0);
    manual_span = 1'b1; strap_span = 4'hA;
    rd_sel = 2'd1;
    do_cmd("R8 span write ignored", 4'h1, 4'h1, 16'h0005, 0);
    do_cmd("R8 strap span on update", 4'h2, 4'h1, 16'h0000, 0);
    rd_sel = 2'd2;
    @(negedge clk); push("R11 readback ch2");
    do_brownout("R10 brownout");
    manual_span = 1'b0;
    do_cmd("R10 R9 update after brownout", 4'h2, 4'hF, 16'h0000, 0);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule